// File: doc/BRIEF.md
# Overlapped Three-Engine Chunk Sequencer

This controller moves one frame, cut into N equal chunks, through three external engines: a copy engine that loads a chunk into local storage, a decrypt engine, and a parse engine. Three local buffers rotate so that one slot can hold the load of one chunk, the decryption of the chunk loaded before it and the parse of the chunk decrypted before that. In each slot the controller raises one-cycle start pulses with a buffer index for each engine. It then waits for the done pulses of the engines it started and moves to the next slot only when all of them have reported.

A frame is launched by pulsing `frame_start` with the chunk count on `num_chunks`. `overlap_en` chooses the rotating schedule (N+2 slots) or a strictly serial schedule (3N slots, one engine per slot). The block reports `busy`, a running slot count, and a one-cycle `frame_done` pulse.

Top module: `chunk_pipe_ctrl`

## Requirements
- R1: After reset `busy`, `frame_done` and all three start outputs are 0 and `slot_count` is 0.
- R2: When idle, a `frame_start` pulse with `num_chunks` of 1 or more begins a frame and raises `busy`. A `num_chunks` of 0 is ignored: `busy` stays low and no start pulse appears.
- R3: Each start output is a pulse of one cycle. Within a slot the starts follow the order copy, then decrypt, then parse, on separate cycles. Stages that have no work in that slot are left out.
- R4: With `overlap_en`=1, in slot k (counted from 0) the copy buffer index is k mod 3, the decrypt index is (k-1) mod 3 and the parse index is (k-2) mod 3. Indices take the values 0, 1 and 2 only.
- R5: With `overlap_en`=1, copy starts in slot k only if k < N. Decrypt starts only if 1 <= k <= N, and parse only if 2 <= k <= N+1.
- R6: A slot ends only after every engine started in it has returned `done`. No engine is started again while its earlier start is still outstanding, and a copy never starts while any engine is outstanding.
- R7: With `overlap_en`=1, a frame takes N+2 slots, so `slot_count` ends at N+2. This gives 3 slots for N=1 and 4 slots for N=2.
- R8: With `overlap_en`=0, a frame takes 3N slots. Slot 3c+p starts only engine p (0 copy, 1 decrypt, 2 parse), with buffer index c mod 3.
- R9: `frame_done` is a single-cycle pulse in the first cycle in which `busy` is low after a frame. `slot_count` then holds its final value until the next accepted `frame_start`.
- R10: A `frame_start` that arrives while `busy` is high is ignored. The running frame keeps its chunk count, its mode and its slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse that launches a frame when idle |
| num_chunks | input | CNT_W | Chunk count N of the frame |
| overlap_en | input | 1 | 1: rotating three-buffer schedule, 0: serial schedule |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at frame completion |
| slot_count | output | CNT_W+2 | Slots completed in the current or last frame |
| copy_start | output | 1 | Start pulse to the copy engine |
| copy_buf | output | 2 | Buffer index for the copy engine |
| copy_done | input | 1 | Completion pulse from the copy engine |
| dec_start | output | 1 | Start pulse to the decrypt engine |
| dec_buf | output | 2 | Buffer index for the decrypt engine |
| dec_done | input | 1 | Completion pulse from the decrypt engine |
| parse_start | output | 1 | Start pulse to the parse engine |
| parse_buf | output | 2 | Buffer index for the parse engine |
| parse_done | input | 1 | Completion pulse from the parse engine |

## Verification
The hardest case to produce is a slot in which parse finishes first and the copy or decrypt engine is still running. This is the case where an early advance would corrupt a buffer. The engine stubs in the bench have a separate latency for each engine, so a fast parse is run against a slow copy and decrypt, and the reverse is also run. Each start is then checked against the stub state, so a start that lands on a busy engine is caught. The ramp slots, where stages are skipped, are reached with N=1 and N=2. Here every slot is a ramp slot and the sequence of (engine, buffer) pairs shows any stage that was wrongly started or wrongly skipped.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int NUM_ENG = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } cpc_state_e;

  typedef logic [1:0] buf_idx_t;

  // one step forward around the three buffers
  function automatic buf_idx_t buf_fwd(input buf_idx_t b);
    return (b == 2'd2) ? 2'd0 : buf_idx_t'(b + 2'd1);
  endfunction

  // one step back around the three buffers
  function automatic buf_idx_t buf_back(input buf_idx_t b);
    return (b == 2'd0) ? 2'd2 : buf_idx_t'(b - 2'd1);
  endfunction
endpackage

// File: rtl/cpc_rst_sync.sv
module cpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cpc_stage_sel.sv
module cpc_stage_sel
  import cpc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SLOT_W = CNT_W + 2
) (
  input  logic                        overlap,
  input  logic [SLOT_W-1:0]           slot_k,
  input  logic [CNT_W-1:0]            n_chunks,
  input  logic [1:0]                  seq_ph,
  input  buf_idx_t                    rot_buf,
  output logic [NUM_ENG-1:0]          stage_vld,
  output logic [NUM_ENG-1:0][1:0]     stage_buf
);
  logic [SLOT_W-1:0]  n_ext;
  logic [NUM_ENG-1:0] vld_ovl;
  logic [NUM_ENG-1:0] vld_seq;

  assign n_ext = SLOT_W'(n_chunks);

  // overlapped schedule: copy k, decrypt k-1, parse k-2
  assign vld_ovl[0] = (slot_k < n_ext);
  assign vld_ovl[1] = (slot_k != '0) && (slot_k <= n_ext);
  assign vld_ovl[2] = (slot_k >= SLOT_W'(2)) && (slot_k <= n_ext + SLOT_W'(1));

  // serial schedule: exactly one engine per slot
  assign vld_seq = NUM_ENG'(3'b001 << seq_ph);

  always_comb begin
    if (overlap) begin
      stage_vld    = vld_ovl;
      stage_buf[0] = rot_buf;
      stage_buf[1] = buf_back(rot_buf);
      stage_buf[2] = buf_fwd(rot_buf);
    end else begin
      stage_vld    = vld_seq;
      stage_buf[0] = rot_buf;
      stage_buf[1] = rot_buf;
      stage_buf[2] = rot_buf;
    end
  end
endmodule

// File: rtl/cpc_pending.sv
module cpc_pending #(
  parameter int NUM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] start,
  input  logic [NUM-1:0] done,
  output logic [NUM-1:0] pend
);
  for (genvar e = 0; e < NUM; e++) begin : g_eng
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend[e] <= 1'b0;
      else if (start[e]) pend[e] <= 1'b1;
      else if (done[e])  pend[e] <= 1'b0;
    end
  end
endmodule

// File: rtl/chunk_pipe_ctrl.sv
module chunk_pipe_ctrl
  import cpc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] num_chunks,
  input  logic             overlap_en,
  output logic             busy,
  output logic             frame_done,
  output logic [CNT_W+1:0] slot_count,
  output logic             copy_start,
  output logic [1:0]       copy_buf,
  input  logic             copy_done,
  output logic             dec_start,
  output logic [1:0]       dec_buf,
  input  logic             dec_done,
  output logic             parse_start,
  output logic [1:0]       parse_buf,
  input  logic             parse_done
);
  localparam int SLOT_W = CNT_W + 2;

  logic rst_s_n;

  cpc_state_e        state_q, state_d;
  logic [1:0]        ph_q, ph_d;
  logic [1:0]        seq_q, seq_d;
  buf_idx_t          rot_q, rot_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [CNT_W-1:0]  n_q, n_d;
  logic              ovl_q, ovl_d;
  logic              fdone_q, fdone_d;

  logic [NUM_ENG-1:0]      stage_vld;
  logic [NUM_ENG-1:0][1:0] stage_buf;
  logic [NUM_ENG-1:0]      starts;
  logic [NUM_ENG-1:0]      dones;
  logic [NUM_ENG-1:0]      pend;
  logic [SLOT_W-1:0]       n_ext;
  logic [SLOT_W-1:0]       total_slots;
  logic                    last_slot;
  logic                    slot_close;

  cpc_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_s_n)
  );

  cpc_stage_sel #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_sel (
    .overlap  (ovl_q),
    .slot_k   (slot_q),
    .n_chunks (n_q),
    .seq_ph   (seq_q),
    .rot_buf  (rot_q),
    .stage_vld(stage_vld),
    .stage_buf(stage_buf)
  );

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_start
    assign starts[e] = (state_q == ST_ISSUE) && (ph_q == 2'(e)) && stage_vld[e];
  end

  assign dones = {parse_done, dec_done, copy_done};

  cpc_pending #(.NUM(NUM_ENG)) u_pend (
    .clk  (clk),
    .rst_n(rst_s_n),
    .start(starts),
    .done (dones),
    .pend (pend)
  );

  assign n_ext       = SLOT_W'(n_q);
  assign total_slots = ovl_q ? (n_ext + SLOT_W'(2)) : ((n_ext << 1) + n_ext);
  assign last_slot   = (slot_q == total_slots - SLOT_W'(1));
  assign slot_close  = (state_q == ST_WAIT) && (pend == '0);

  // next-state logic
  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    seq_d   = seq_q;
    rot_d   = rot_q;
    slot_d  = slot_q;
    n_d     = n_q;
    ovl_d   = ovl_q;
    fdone_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_start && (num_chunks != '0)) begin
          state_d = ST_ISSUE;
          n_d     = num_chunks;
          ovl_d   = overlap_en;
          ph_d    = 2'd0;
          seq_d   = 2'd0;
          rot_d   = 2'd0;
          slot_d  = '0;
        end
      end
      ST_ISSUE: begin
        if (ph_q == 2'd2) begin
          ph_d    = 2'd0;
          state_d = ST_WAIT;
        end else begin
          ph_d = ph_q + 2'd1;
        end
      end
      ST_WAIT: begin
        if (slot_close) begin
          slot_d = slot_q + SLOT_W'(1);
          seq_d  = (seq_q == 2'd2) ? 2'd0 : seq_q + 2'd1;
          if (ovl_q || (seq_q == 2'd2)) rot_d = buf_fwd(rot_q);
          if (last_slot) begin
            state_d = ST_IDLE;
            fdone_d = 1'b1;
          end else begin
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      ph_q    <= 2'd0;
      seq_q   <= 2'd0;
      rot_q   <= 2'd0;
      slot_q  <= '0;
      n_q     <= '0;
      ovl_q   <= 1'b0;
      fdone_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      seq_q   <= seq_d;
      rot_q   <= rot_d;
      slot_q  <= slot_d;
      n_q     <= n_d;
      ovl_q   <= ovl_d;
      fdone_q <= fdone_d;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign frame_done  = fdone_q;
  assign slot_count  = slot_q;
  assign copy_start  = starts[0];
  assign dec_start   = starts[1];
  assign parse_start = starts[2];
  assign copy_buf    = stage_buf[0];
  assign dec_buf     = stage_buf[1];
  assign parse_buf   = stage_buf[2];
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             frame_done,
  input logic [CNT_W+1:0] slot_count,
  input logic             copy_start,
  input logic [1:0]       copy_buf,
  input logic             copy_done,
  input logic             dec_start,
  input logic [1:0]       dec_buf,
  input logic             dec_done,
  input logic             parse_start,
  input logic [1:0]       parse_buf,
  input logic             parse_done
);
  logic [2:0] st;
  logic [2:0] dn;
  logic [2:0] outst;

  assign st = {parse_start, dec_start, copy_start};
  assign dn = {parse_done, dec_done, copy_done};

  // independent model of outstanding engine work
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 3'b000;
    else        outst <= st | (outst & ~dn);
  end

  p_one_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (st == 3'b000));

  p_buf_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_buf != 2'd3) && (dec_buf != 2'd3) && (parse_buf != 2'd3));

  p_copy_barrier_r6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |-> (outst == 3'b000));

  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st & outst) == 3'b000);

  p_done_at_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> frame_done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy);

  p_count_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (slot_count >= $past(slot_count)));
endmodule

bind chunk_pipe_ctrl cpc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .frame_done (frame_done),
  .slot_count (slot_count),
  .copy_start (copy_start),
  .copy_buf   (copy_buf),
  .copy_done  (copy_done),
  .dec_start  (dec_start),
  .dec_buf    (dec_buf),
  .dec_done   (dec_done),
  .parse_start(parse_start),
  .parse_buf  (parse_buf),
  .parse_done (parse_done)
);

// File: tb/chunk_pipe_ctrl_tb_top.sv
`timescale 1ns/1ps
module chunk_pipe_ctrl_tb_top;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_start = 1'b0;
  logic [CNT_W-1:0] num_chunks = '0;
  logic             overlap_en = 1'b0;
  logic             busy, frame_done;
  logic [CNT_W+1:0] slot_count;
  logic             copy_start, dec_start, parse_start;
  logic [1:0]       copy_buf, dec_buf, parse_buf;
  logic             copy_done = 1'b0, dec_done = 1'b0, parse_done = 1'b0;

  always #10 clk = ~clk;

  chunk_pipe_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .num_chunks(num_chunks), .overlap_en(overlap_en),
    .busy(busy), .frame_done(frame_done), .slot_count(slot_count),
    .copy_start(copy_start), .copy_buf(copy_buf), .copy_done(copy_done),
    .dec_start(dec_start), .dec_buf(dec_buf), .dec_done(dec_done),
    .parse_start(parse_start), .parse_buf(parse_buf), .parse_done(parse_done)
  );

  int total = 0;
  int bad   = 0;

  int lat [3];
  int cnt [3];
  int ev_eng [64];
  int ev_buf [64];
  int ev_n = 0;
  int fd_cnt = 0;
  int barrier_err = 0;
  int exp_eng [64];
  int exp_buf [64];
  int exp_n;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // engine stubs and start logger
  always @(negedge clk) begin
    logic [2:0] s;
    logic [1:0] b [3];
    s = {parse_start, dec_start, copy_start};
    b[0] = copy_buf; b[1] = dec_buf; b[2] = parse_buf;
    copy_done = 1'b0; dec_done = 1'b0; parse_done = 1'b0;
    if (frame_done) fd_cnt++;
    for (int e = 0; e < 3; e++) begin
      if (s[e]) begin
        if (cnt[e] != 0) barrier_err++;
        if (e == 0 && (cnt[1] != 0 || cnt[2] != 0)) barrier_err++;
        if (ev_n < 64) begin
          ev_eng[ev_n] = e;
          ev_buf[ev_n] = int'(b[e]);
        end
        ev_n++;
        cnt[e] = lat[e];
      end else if (cnt[e] > 0) begin
        cnt[e]--;
        if (cnt[e] == 0) begin
          if (e == 0) copy_done = 1'b1;
          if (e == 1) dec_done = 1'b1;
          if (e == 2) parse_done = 1'b1;
        end
      end
    end
  end

  task automatic push_exp(input int e, input int b);
    exp_eng[exp_n] = e;
    exp_buf[exp_n] = b;
    exp_n++;
  endtask

  task automatic run_frame(input int n, input bit ovl, input int l0, input int l1,
                           input int l2, input int poke_at);
    int cyc;
    int mism;
    int first_bad;
    int exp_slots;
    lat[0] = l0; lat[1] = l1; lat[2] = l2;
    exp_n = 0;
    if (ovl) begin
      for (int k = 0; k < n + 2; k++) begin
        if (k < n)               push_exp(0, k % 3);
        if (k >= 1 && k <= n)    push_exp(1, (k - 1) % 3);
        if (k >= 2 && k <= n+1)  push_exp(2, (k - 2) % 3);
      end
      exp_slots = n + 2;
    end else begin
      for (int c = 0; c < n; c++)
        for (int p = 0; p < 3; p++) push_exp(p, c % 3);
      exp_slots = 3 * n;
    end
    @(negedge clk);
    ev_n = 0; fd_cnt = 0; barrier_err = 0;
    frame_start = 1'b1; num_chunks = CNT_W'(n); overlap_en = ovl;
    @(negedge clk);
    frame_start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    cyc = 0;
    while (!frame_done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke_at > 0 && cyc == poke_at) begin
        frame_start = 1'b1; num_chunks = CNT_W'(7); overlap_en = ~ovl;
      end else if (poke_at > 0 && cyc == poke_at + 1) begin
        frame_start = 1'b0; num_chunks = '0;
      end
    end
    check(frame_done == 1'b1, "R9", "frame_done seen", int'(frame_done), 1);
    check(busy == 1'b0, "R9", "busy low at frame_done", int'(busy), 0);
    repeat (4) @(negedge clk);
    check(fd_cnt == 1, "R9", "frame_done pulse count", fd_cnt, 1);
    check(int'(slot_count) == exp_slots, ovl ? "R7" : "R8", "slot count",
          int'(slot_count), exp_slots);
    check(ev_n == exp_n, ovl ? "R5" : "R8", "start count", ev_n, exp_n);
    mism = 0; first_bad = -1;
    for (int i = 0; i < exp_n && i < ev_n && i < 64; i++) begin
      if (ev_eng[i] != exp_eng[i] || ev_buf[i] != exp_buf[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    end
    check(mism == 0, ovl ? "R3 R4" : "R8", "start order/buffer mismatches", mism, 0);
    if (first_bad >= 0)
      $display("  first mismatch at %0d: eng=%0d buf=%0d exp eng=%0d buf=%0d", first_bad,
               ev_eng[first_bad], ev_buf[first_bad], exp_eng[first_bad], exp_buf[first_bad]);
    check(barrier_err == 0, "R6", "starts on busy engine", barrier_err, 0);
  endtask

  task automatic test_reset;
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(frame_done == 1'b0, "R1", "frame_done after reset", int'(frame_done), 0);
    check(int'(slot_count) == 0, "R1", "slot_count after reset", int'(slot_count), 0);
    check({copy_start, dec_start, parse_start} == 3'b000, "R1", "starts after reset",
          int'({copy_start, dec_start, parse_start}), 0);
  endtask

  task automatic test_zero_chunks;
    int keep;
    keep = int'(slot_count);
    @(negedge clk);
    ev_n = 0;
    frame_start = 1'b1; num_chunks = '0; overlap_en = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R2", "busy with zero chunks", int'(busy), 0);
    check(ev_n == 0, "R2", "starts with zero chunks", ev_n, 0);
    check(int'(slot_count) == keep, "R9", "slot_count held while idle", int'(slot_count), keep);
  endtask

  initial begin
    for (int e = 0; e < 3; e++) begin lat[e] = 1; cnt[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    run_frame(4, 1'b1, 3, 5, 2, 0);      // mixed latencies
    run_frame(1, 1'b1, 2, 2, 2, 0);      // R7 N=1 takes 3 slots
    run_frame(2, 1'b1, 1, 4, 1, 0);      // R7 N=2 takes 4 slots
    run_frame(5, 1'b1, 9, 8, 1, 0);      // R6 parse fast, others slow
    run_frame(6, 1'b1, 1, 1, 7, 0);      // R6 parse slow
    run_frame(3, 1'b0, 2, 3, 4, 0);      // R8 serial mode
    run_frame(1, 1'b0, 1, 1, 1, 0);      // R8 serial single chunk
    run_frame(4, 1'b1, 2, 2, 2, 9);      // R10 start ignored while busy
    test_zero_chunks();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule